// File: doc/BRIEF.md
# Interprocessor interrupt destination matcher

This block sits beside a group of local interrupt controllers and turns a write of an interrupt command into a set of receiving controllers. Software programs a high command word that carries an 8-bit destination. It then writes the low command word, which carries the vector, the delivery mode, the assert level, the trigger mode, the destination mode and a shorthand. The low write both stores the word and starts a dispatch at once. The block compares the destination with every target's physical ID, or with its logical ID under that target's format model. It returns a target mask together with the fields that are forwarded to the targets.

Each target has two registers held inside this block: a destination format register and a logical ID register. Each target's physical ID arrives on an input bus. The sender is named by a source index, which the shorthands use. For lowest-priority delivery the matching set is reduced to a single target. Accepting the interrupt into each target's pending state is left to the targets.

Top module: `ipi_dest_matcher`

## Requirements
- R1: Shorthand 1 (low command bits 19:18) delivers to the source target only, whatever the destination field holds.
- R2: Shorthand 2 delivers to every target, the source included.
- R3: Shorthand 3 delivers to every target except the source.
- R4: With shorthand 0 and bit 11 at 0 (physical mode), a target matches when the destination (high command bits 31:24) equals its 8-bit physical ID, or when the destination is 0xFF.
- R5: With shorthand 0 and bit 11 at 1, a target whose format bits 31:28 are 0xF (flat) matches when its logical ID (bits 31:24) ANDed with the destination is nonzero.
- R6: A target whose format bits 31:28 are 0x0 (cluster) matches when the upper nibbles of its logical ID and the destination are equal and the AND of the lower nibbles is nonzero. Any other format value never matches in logical mode.
- R7: A write to the high command register (select 1) keeps only bits 31:24 and clears the rest.
- R8: A write to the low command register (select 0) stores the value with bit 12 cleared. In the next cycle, and only then, out_valid is high with vector = bits 7:0, delivery mode = bits 10:8, level = bit 14 and trigger = bit 15.
- R9: When the delivery mode is 1 (lowest priority), only the highest-indexed matching target is set in the mask. With no match the mask is zero.
- R10: A write to a format register (select 2) stores the data with bits 27:0 forced to ones. A write to a logical ID register (select 3) keeps only bits 31:24.
- R11: After reset, both command registers and every logical ID read zero, every format register reads all ones, and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 low command, 1 high command, 2 format, 3 logical ID |
| wr_tgt | input | TW | Target index for format and logical ID writes |
| wr_data | input | 32 | Write data |
| src_idx | input | TW | Index of the sending target |
| phys_id | input | NT*8 | Physical ID of each target, target i in bits 8i+7:8i |
| rd_sel | input | 2 | Read register select, same coding as wr_sel |
| rd_tgt | input | TW | Target index for reads |
| rd_data | output | 32 | Combinational read data |
| out_valid | output | 1 | Dispatch result valid |
| out_mask | output | NT | Receiving targets |
| out_vector | output | 8 | Forwarded vector |
| out_dlv | output | 3 | Forwarded delivery mode |
| out_level | output | 1 | Forwarded assert level |
| out_trig | output | 1 | Forwarded trigger mode |

## Verification
The bench builds the block with four targets. That is small enough to sweep all 256 destination values in physical, flat and cluster modes, each in both fixed and lowest-priority delivery, and every shorthand from every source index. The physical IDs include a duplicate and the logical IDs overlap, so lowest-priority reduction meets multi-target matches. One target carries an undefined format model to show that it never matches.

// File: rtl/ipi_dest_matcher.sv
module ipi_dest_matcher #(
  parameter int NT = 4,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [TW-1:0]   wr_tgt,
  input  logic [31:0]     wr_data,
  input  logic [TW-1:0]   src_idx,
  input  logic [NT*8-1:0] phys_id,
  input  logic [1:0]      rd_sel,
  input  logic [TW-1:0]   rd_tgt,
  output logic [31:0]     rd_data,
  output logic            out_valid,
  output logic [NT-1:0]   out_mask,
  output logic [7:0]      out_vector,
  output logic [2:0]      out_dlv,
  output logic            out_level,
  output logic            out_trig
);

  localparam logic [2:0] DLV_LOWEST = 3'd1;
  localparam logic [3:0] MODEL_FLAT = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;

  logic [31:0] cmd_lo, cmd_hi;
  logic [31:0] fmt_q [NT];
  logic [31:0] ldr_q [NT];

  wire       go      = wr_en && (wr_sel == 2'd0);
  wire [7:0] dest    = cmd_hi[31:24];
  wire [1:0] sh      = wr_data[19:18];
  wire       logical = wr_data[11];
  wire [2:0] dlv     = wr_data[10:8];

  logic [NT-1:0] hit, pick, mask_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_lo <= '0;
      cmd_hi <= '0;
      for (int i = 0; i < NT; i++) begin
        fmt_q[i] <= '1;
        ldr_q[i] <= '0;
      end
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: cmd_lo <= wr_data & ~32'h0000_1000;
        2'd1: cmd_hi <= {wr_data[31:24], 24'h0};
        2'd2: fmt_q[wr_tgt] <= wr_data | 32'h0FFF_FFFF;
        default: ldr_q[wr_tgt] <= {wr_data[31:24], 24'h0};
      endcase
    end
  end

  for (genvar g = 0; g < NT; g++) begin : g_tgt
    wire [7:0] pid   = phys_id[g*8 +: 8];
    wire [7:0] lid   = ldr_q[g][31:24];
    wire [3:0] model = fmt_q[g][31:28];
    wire       is_src = (src_idx == TW'(g));
    wire phys_hit = (dest == pid) || (dest == 8'hFF);
    wire flat_hit = (model == MODEL_FLAT) && ((lid & dest) != 8'h0);
    wire clus_hit = (model == MODEL_CLUSTER) && (lid[7:4] == dest[7:4]) &&
                    ((lid[3:0] & dest[3:0]) != 4'h0);
    always_comb begin
      case (sh)
        2'd1:    hit[g] = is_src;
        2'd2:    hit[g] = 1'b1;
        2'd3:    hit[g] = !is_src;
        default: hit[g] = logical ? (flat_hit || clus_hit) : phys_hit;
      endcase
    end
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i < NT; i++) begin
      if (hit[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  assign mask_next = (dlv == DLV_LOWEST) ? pick : hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_mask   <= '0;
      out_vector <= '0;
      out_dlv    <= '0;
      out_level  <= 1'b0;
      out_trig   <= 1'b0;
    end else begin
      out_valid <= go;
      if (go) begin
        out_mask   <= mask_next;
        out_vector <= wr_data[7:0];
        out_dlv    <= dlv;
        out_level  <= wr_data[14];
        out_trig   <= wr_data[15];
      end
    end
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = cmd_lo;
      2'd1:    rd_data = cmd_hi;
      2'd2:    rd_data = fmt_q[rd_tgt];
      default: rd_data = ldr_q[rd_tgt];
    endcase
  end

  p_valid_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> out_valid);

  p_valid_only_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 2'd0) |=> !out_valid);

  p_lowest_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_dlv == DLV_LOWEST) |-> $onehot0(out_mask));

  p_self_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && wr_data[19:18] == 2'd1) |=>
      (out_mask == (NT'(1) << $past(src_idx))));

  p_excl_self_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && wr_data[19:18] == 2'd3 && wr_data[10:8] != DLV_LOWEST) |=>
      ($countones(out_mask) == NT - 1 && !out_mask[$past(src_idx)]));

endmodule

// File: tb/ipi_dest_matcher_tb.sv
`timescale 1ns/1ps
module ipi_dest_matcher_tb;
  localparam int NT = 4;
  localparam int TW = 2;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0;
  logic [TW-1:0] wr_tgt = 0, src_idx = 0, rd_tgt = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [NT*8-1:0] phys_id;
  logic out_valid, out_level, out_trig;
  logic [NT-1:0] out_mask;
  logic [7:0] out_vector;
  logic [2:0] out_dlv;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] ids [NT];
  logic [31:0] fmtv [NT], ldrv [NT];
  logic [7:0] hdest = 0;

  always #2.5 clk = ~clk;
  assign phys_id = {ids[3], ids[2], ids[1], ids[0]};

  ipi_dest_matcher #(.NT(NT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_tgt(wr_tgt),
    .wr_data(wr_data), .src_idx(src_idx), .phys_id(phys_id), .rd_sel(rd_sel),
    .rd_tgt(rd_tgt), .rd_data(rd_data), .out_valid(out_valid), .out_mask(out_mask),
    .out_vector(out_vector), .out_dlv(out_dlv), .out_level(out_level), .out_trig(out_trig));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input int t, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_tgt = TW'(t); wr_data = d;
    if (s == 2'd1) hdest = d[31:24];
    if (s == 2'd2) fmtv[t] = d | 32'h0FFF_FFFF;
    if (s == 2'd3) ldrv[t] = {d[31:24], 24'h0};
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] s, input int t, output logic [31:0] d);
    rd_sel = s; rd_tgt = TW'(t);
    #0.5;
    d = rd_data;
  endtask

  function automatic logic [NT-1:0] expm(input logic [31:0] lo, input int src);
    logic [NT-1:0] m = '0;
    logic [NT-1:0] one = '0;
    for (int i = 0; i < NT; i++) begin
      case (lo[19:18])
        2'd1: m[i] = (i == src);
        2'd2: m[i] = 1'b1;
        2'd3: m[i] = (i != src);
        default: begin
          if (!lo[11]) m[i] = (hdest == ids[i]) || (hdest == 8'hFF);
          else if (fmtv[i][31:28] == 4'hF) m[i] = (ldrv[i][31:24] & hdest) != 0;
          else if (fmtv[i][31:28] == 4'h0)
            m[i] = (ldrv[i][31:28] == hdest[7:4]) && ((ldrv[i][27:24] & hdest[3:0]) != 0);
          else m[i] = 1'b0;
        end
      endcase
    end
    if (lo[10:8] == 3'd1) begin
      for (int i = 0; i < NT; i++) if (m[i]) begin one = '0; one[i] = 1'b1; end
      m = one;
    end
    return m;
  endfunction

  task automatic dispatch(input string tag, input logic [31:0] lo, input int src);
    src_idx = TW'(src);
    wr(2'd0, 0, lo);
    chk({tag, " valid"}, 32'(out_valid), 32'd1);
    chk({tag, " mask"}, 32'(out_mask), 32'(expm(lo, src)));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    ids[0] = 8'h05; ids[1] = 8'h07; ids[2] = 8'h05; ids[3] = 8'h10;
    for (int i = 0; i < NT; i++) begin fmtv[i] = '1; ldrv[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 valid", 32'(out_valid), 0);
    rd(0, 0, d); chk("R11 lo", d, 0);
    rd(1, 0, d); chk("R11 hi", d, 0);
    for (int i = 0; i < NT; i++) begin
      rd(2, i, d); chk("R11 fmt", d, 32'hFFFF_FFFF);
      rd(3, i, d); chk("R11 ldr", d, 0);
    end
    // R7 high command masking
    wr(1, 0, 32'hABCD_EF12); rd(1, 0, d); chk("R7 hi", d, 32'hAB00_0000);
    // R10 format / logical masking
    wr(2, 1, 32'h5000_0005); rd(2, 1, d); chk("R10 fmt", d, 32'h5FFF_FFFF);
    wr(3, 1, 32'h1234_5678); rd(3, 1, d); chk("R10 ldr", d, 32'h1200_0000);
    wr(2, 1, 32'hF000_0000);
    // R8 field forwarding, pending bit cleared, one-cycle valid
    for (int k = 0; k < 8; k++) begin
      logic [31:0] lo = {16'h0, k[0], k[1], 1'b0, 1'b1, 1'b0, k[2:0], 8'h30 + 8'(k * 7)};
      dispatch("R8", lo, 0);
      chk("R8 vector", 32'(out_vector), 32'(lo[7:0]));
      chk("R8 dlv", 32'(out_dlv), 32'(lo[10:8]));
      chk("R8 level", 32'(out_level), 32'(lo[14]));
      chk("R8 trig", 32'(out_trig), 32'(lo[15]));
      rd(0, 0, d); chk("R8 stored", d, lo & ~32'h1000);
      @(negedge clk);
      chk("R8 valid drop", 32'(out_valid), 0);
    end
    // R1 R2 R3 shorthands, both delivery modes, every source
    for (int s = 0; s < NT; s++)
      for (int dm = 0; dm < 2; dm++) begin
        dispatch("R1", 32'h0004_0041 | (dm << 8), s);
        dispatch("R2", 32'h0008_0041 | (dm << 8), s);
        dispatch("R3", 32'h000C_0041 | (dm << 8), s);
      end
    // R4 physical sweep, R9 lowest priority
    for (int dv = 0; dv < 256; dv++) begin
      wr(1, 0, {8'(dv), 24'h0});
      dispatch("R4", 32'h0000_0050, 1);
      dispatch("R9 phys", 32'h0000_0150, 1);
    end
    // R5 flat logical sweep
    for (int i = 0; i < NT; i++) wr(2, i, 32'hFFFF_FFFF);
    wr(3, 0, 32'h0100_0000); wr(3, 1, 32'h0200_0000);
    wr(3, 2, 32'h0600_0000); wr(3, 3, 32'h8000_0000);
    for (int dv = 0; dv < 256; dv++) begin
      wr(1, 0, {8'(dv), 24'h0});
      dispatch("R5", 32'h0000_0860, 2);
      dispatch("R9 flat", 32'h0000_0960, 2);
    end
    // R6 cluster logical sweep with one undefined model
    wr(2, 0, 32'h0); wr(2, 1, 32'h0); wr(2, 2, 32'h0); wr(2, 3, 32'h5000_0000);
    wr(3, 0, 32'h1100_0000); wr(3, 1, 32'h1300_0000);
    wr(3, 2, 32'h2300_0000); wr(3, 3, 32'h2F00_0000);
    for (int dv = 0; dv < 256; dv++) begin
      wr(1, 0, {8'(dv), 24'h0});
      dispatch("R6", 32'h0000_0870, 3);
      dispatch("R9 clus", 32'h0000_0970, 3);
    end
    wr(1, 0, 32'h2F00_0000);
    dispatch("R6 undefined", 32'h0000_0870, 0);
    chk("R6 undefined target", 32'(out_mask[3]), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule